// File: doc/BRIEF.md
# Sequential Double-Width Integer Divider

This block divides a dividend of twice the operand width by a divisor of the operand width. It returns a quotient and a remainder, each of the operand width. A size input picks an operand width of 8, 16 or 32 bits. A mode input picks unsigned or signed (two's complement) arithmetic. The caller must extend the sign of a signed dividend to the full double width before it asserts start.

The work starts on a one-cycle start pulse. The divider checks both error cases before it iterates:

- A zero divisor ends the operation on the next edge and raises the divide-by-zero flag.
- A quotient that can never fit the operand width ends the operation on the next edge and raises the overflow flag.

Otherwise the core runs a restoring shift-subtract loop that produces one quotient bit per clock. In signed mode the loop works on magnitudes. The signs are applied when the loop ends, and a signed quotient outside the destination range is reported as an overflow at that point.

Results are held in output registers. They change only when an operation finishes without an error.

Top module: `dual_width_divider`

## Requirements
- R1: With no error, an unsigned operation returns floor(dividend / divisor) in quotient[W-1:0] and dividend mod divisor in remainder[W-1:0]. The bits above W on both outputs are zero.
- R2: size_sel selects W: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 gives 32 bits. Only dividend[2W-1:0] and divisor[W-1:0] are used. Higher input bits have no effect.
- R3: In signed mode the quotient is rounded toward zero. The remainder takes the sign of the dividend, so 0xFFD0 (-48) divided by 0x05 at W=8 gives quotient 0xF7 (-9) and remainder 0xFD (-3).
- R4: A zero divisor (divisor[W-1:0]==0) raises done and div_zero on the edge that accepts start. busy never rises for that operation.
- R5: If the quotient magnitude is 2^W or more, done and div_ovf rise on the edge that accepts start, with no iteration.
- R6: In signed mode, a quotient magnitude above 2^(W-1)-1 (for a positive result) or above 2^(W-1) (for a negative result) raises div_ovf together with done at the end of the iteration.
- R7: An accepted operation with no early error holds busy high for exactly W cycles. done is a one-cycle pulse on the edge where busy falls, and is never high while busy is high.
- R8: An operation that ends with div_zero or div_ovf leaves quotient and remainder at their previous values.
- R9: start is ignored while busy is high. The running operation completes with its original operands.
- R10: After reset, busy, done, div_zero, div_ovf, quotient and remainder are all zero.
- R11: div_zero and div_ovf are never both high. They keep their values until the next accepted start, which clears them or sets them for the new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when not busy |
| signed_mode | input | 1 | 1 = two's complement, 0 = unsigned |
| size_sel | input | 2 | Operand width select (R2) |
| dividend | input | 2*XLEN | Double-width dividend |
| divisor | input | XLEN | Single-width divisor |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | XLEN | Registered quotient, zero-extended from W bits |
| remainder | output | XLEN | Registered remainder, zero-extended from W bits |
| div_zero | output | 1 | Last operation had a zero divisor |
| div_ovf | output | 1 | Last operation's quotient did not fit |

## Verification
The assertions assume three things about the inputs:

- start is a level sampled on each edge.
- size_sel and divisor are stable in the cycle where start is accepted.
- The caller does not depend on the result registers moving except on a done pulse.

The bench changes inputs only on the falling clock edge, so each accepted start sees settled operands. It uses both constructed operands, whose quotients fit by design, and raw random operands, which exercise both overflow paths and the zero-divisor path. Starts are also issued during iteration to confirm they are dropped.

// File: rtl/dual_width_divider.sv
module dual_width_divider #(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              signed_mode,
  input  logic [1:0]        size_sel,
  input  logic [2*XLEN-1:0] dividend,
  input  logic [XLEN-1:0]   divisor,
  output logic              busy,
  output logic              done,
  output logic [XLEN-1:0]   quotient,
  output logic [XLEN-1:0]   remainder,
  output logic              div_zero,
  output logic              div_ovf
);
  localparam int CW = $clog2(XLEN + 1);
  localparam int DW = 2 * XLEN;

  int                wsel;
  logic [XLEN-1:0]   msk_w, half_w, dv, dv_top, vmag, dmag_hi, dmag_lo_al;
  logic [DW-1:0]     msk_2w, dd, dd_top, dmag, dmag_sh;
  logic              sd, sv, dv_zero, ovf_early;

  always_comb begin
    case (size_sel)
      2'd0:    wsel = XLEN / 4;
      2'd1:    wsel = XLEN / 2;
      default: wsel = XLEN;
    endcase
  end

  assign msk_w   = {XLEN{1'b1}} >> (XLEN - wsel);
  assign msk_2w  = {DW{1'b1}} >> (DW - 2 * wsel);
  assign half_w  = {{(XLEN-1){1'b0}}, 1'b1} << (wsel - 1);
  assign dd      = dividend & msk_2w;
  assign dv      = divisor & msk_w;
  assign dd_top  = dd >> (2 * wsel - 1);
  assign dv_top  = dv >> (wsel - 1);
  assign sd      = signed_mode & dd_top[0];
  assign sv      = signed_mode & dv_top[0];
  assign dmag    = sd ? ((~dd + 1'b1) & msk_2w) : dd;
  assign vmag    = sv ? ((~dv + 1'b1) & msk_w) : dv;
  assign dmag_sh = dmag >> wsel;
  assign dmag_hi = dmag_sh[XLEN-1:0];
  assign dmag_lo_al = dmag[XLEN-1:0] << (XLEN - wsel);
  assign dv_zero   = (dv == '0);
  assign ovf_early = (dmag_hi >= vmag);

  logic            busy_q, done_q, zero_q, ovf_q;
  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] rem_acc, quo_sh, dvs, mskl, halfl, quotient_q, remainder_q;
  logic            neg_q, neg_r, sgn_l;

  logic [XLEN:0]   trial;
  logic            ge;
  logic [XLEN-1:0] nxt_rem, nxt_quo, qmag, qres, rres;
  logic            ovf_late;

  assign trial   = {rem_acc, quo_sh[XLEN-1]};
  assign ge      = (trial >= {1'b0, dvs});
  assign nxt_rem = ge ? (trial[XLEN-1:0] - dvs) : trial[XLEN-1:0];
  assign nxt_quo = {quo_sh[XLEN-2:0], ge};
  assign qmag    = nxt_quo & mskl;
  assign qres    = neg_q ? ((~qmag + 1'b1) & mskl) : qmag;
  assign rres    = neg_r ? ((~nxt_rem + 1'b1) & mskl) : nxt_rem;
  assign ovf_late = sgn_l && (neg_q ? (qmag > halfl) : (qmag >= halfl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      zero_q      <= 1'b0;
      ovf_q       <= 1'b0;
      cnt         <= '0;
      rem_acc     <= '0;
      quo_sh      <= '0;
      dvs         <= '0;
      mskl        <= '0;
      halfl       <= '0;
      neg_q       <= 1'b0;
      neg_r       <= 1'b0;
      sgn_l       <= 1'b0;
      quotient_q  <= '0;
      remainder_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        zero_q <= dv_zero;
        ovf_q  <= !dv_zero && ovf_early;
        if (dv_zero || ovf_early) begin
          done_q <= 1'b1;
        end else begin
          busy_q  <= 1'b1;
          cnt     <= CW'(wsel);
          rem_acc <= dmag_hi;
          quo_sh  <= dmag_lo_al;
          dvs     <= vmag;
          mskl    <= msk_w;
          halfl   <= half_w;
          neg_q   <= sd ^ sv;
          neg_r   <= sd;
          sgn_l   <= signed_mode;
        end
      end else if (busy_q) begin
        rem_acc <= nxt_rem;
        quo_sh  <= nxt_quo;
        cnt     <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (ovf_late) begin
            ovf_q <= 1'b1;
          end else begin
            quotient_q  <= qres;
            remainder_q <= rres;
          end
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign div_zero  = zero_q;
  assign div_ovf   = ovf_q;
  assign quotient  = quotient_q;
  assign remainder = remainder_q;
endmodule

// File: rtl/dual_width_divider_chk.sv
module dual_width_divider_chk #(
  parameter int XLEN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        size_sel,
  input logic [XLEN-1:0]   divisor,
  input logic              busy,
  input logic              done,
  input logic [XLEN-1:0]   quotient,
  input logic [XLEN-1:0]   remainder,
  input logic              div_zero,
  input logic              div_ovf
);
  logic zero_in;
  assign zero_in = (size_sel == 2'd0) ? (divisor[XLEN/4-1:0] == '0) :
                   (size_sel == 2'd1) ? (divisor[XLEN/2-1:0] == '0) :
                                        (divisor == '0);

  a_r4_zero_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && zero_in |=> done && div_zero && !busy);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({div_zero, div_ovf}));

  a_r11_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && !busy) |=> $stable({div_zero, div_ovf}) || done);

  a_r8_error_holds_result: assert property (@(posedge clk) disable iff (!rst_n)
    done && (div_zero || div_ovf) |-> $stable(quotient) && $stable(remainder));

  a_r1_result_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(quotient) && $stable(remainder));
endmodule

bind dual_width_divider dual_width_divider_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
  .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
  .remainder(remainder), .div_zero(div_zero), .div_ovf(div_ovf)
);

// File: tb/dual_width_divider_tb_top.sv
module dual_width_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [1:0]  size_sel = 2'd0;
  logic [63:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done, div_zero, div_ovf;
  logic [31:0] quotient, remainder;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  dual_width_divider #(.XLEN(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .size_sel(size_sel), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .div_zero(div_zero), .div_ovf(div_ovf)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ref_op(input bit sgn, input logic [1:0] sz, input logic [63:0] a, input logic [31:0] b,
                        output bit ez, output bit eo, output bit lo,
                        output logic [31:0] q, output logic [31:0] r, output int w);
    logic [63:0] m2, m1, dd, dv, dm, vm, qq, rr, half;
    bit sd, sv, qn;
    w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m2 = (w == 32) ? {64{1'b1}} : ((64'd1 << (2*w)) - 64'd1);
    m1 = (64'd1 << w) - 64'd1;
    dd = a & m2;
    dv = {32'd0, b} & m1;
    sd = sgn && dd[2*w-1];
    sv = sgn && dv[w-1];
    dm = sd ? ((~dd + 64'd1) & m2) : dd;
    vm = sv ? ((~dv + 64'd1) & m1) : dv;
    ez = (dv == 0);
    eo = 1'b0; lo = 1'b0; q = '0; r = '0;
    if (!ez) begin
      qq = dm / vm;
      rr = dm % vm;
      eo = ((qq >> w) != 0);
      qn = sd ^ sv;
      half = 64'd1 << (w-1);
      lo = !eo && sgn && (qn ? (qq > half) : (qq >= half));
      q = 32'(qn ? ((~qq + 64'd1) & m1) : qq);
      r = 32'(sd ? ((~rr + 64'd1) & m1) : rr);
    end
  endtask

  bit m_busy, m_done, m_z, m_o, p_o;
  int m_cnt;
  logic [31:0] m_q, m_r, p_q, p_r;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_z = 0; m_o = 0; m_cnt = 0; m_q = '0; m_r = '0;
    end else begin
      m_done = 0;
      if (start && !m_busy) begin
        bit ez, eo, lo; logic [31:0] q, r; int w;
        ref_op(signed_mode, size_sel, dividend, divisor, ez, eo, lo, q, r, w);
        m_z = ez; m_o = eo;
        if (ez || eo) m_done = 1;
        else begin m_busy = 1; m_cnt = w; p_q = q; p_r = r; p_o = lo; end
      end else if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          if (p_o) m_o = 1;
          else begin m_q = p_q; m_r = p_r; end
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(busy == m_busy, "R7 busy", 64'(busy), 64'(m_busy));
      check(done == m_done, "R7 done", 64'(done), 64'(m_done));
      check(quotient == m_q, "R1 quotient", 64'(quotient), 64'(m_q));
      check(remainder == m_r, "R1 remainder", 64'(remainder), 64'(m_r));
      check(div_zero == m_z, "R4 div_zero", 64'(div_zero), 64'(m_z));
      check(div_ovf == m_o, "R5 div_ovf", 64'(div_ovf), 64'(m_o));
    end
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic go(input bit sgn, input logic [1:0] sz, input logic [63:0] a, input logic [31:0] b, output int lat);
    @(negedge clk);
    signed_mode = sgn; size_sel = sz; dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    logic [31:0] q0, r0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !div_zero && !div_ovf, "R10 flags", {busy, done, div_zero, div_ovf}, 0);
    check(quotient == 0 && remainder == 0, "R10 results", {quotient, remainder}, 0);
    rst_n = 1'b1;

    go(0, 2'd0, 64'd200, 32'd7, lat);
    check(quotient == 28 && remainder == 4, "R1 u8", {quotient, remainder}, {32'd28, 32'd4});
    check(lat == 9, "R7 latency w8", lat, 9);

    go(0, 2'd0, 64'hDEAD_BEEF_0000_00C8, 32'hFFFF_FF07, lat);
    check(quotient == 28 && remainder == 4, "R2 upper bits ignored", {quotient, remainder}, {32'd28, 32'd4});

    go(1, 2'd0, 64'h0000_0000_0000_FFD0, 32'd5, lat);
    check(quotient == 32'hF7 && remainder == 32'hFD, "R3 -48/5", {quotient, remainder}, {32'hF7, 32'hFD});

    go(1, 2'd1, 64'hFFFF_FFFF_FFFF_FF9C, 32'hFFF9, lat);
    check(quotient == 32'h000E && remainder == 32'hFFFE, "R3 -100/-7", {quotient, remainder}, {32'hE, 32'hFFFE});
    check(lat == 17, "R7 latency w16", lat, 17);
    q0 = quotient; r0 = remainder;

    go(0, 2'd2, 64'd12345, 32'd0, lat);
    check(div_zero && !div_ovf && lat == 1, "R4 zero divisor", {div_zero, div_ovf, 8'(lat)}, {1'b1, 1'b0, 8'd1});
    check(quotient == q0 && remainder == r0, "R8 zero keeps result", {quotient, remainder}, {q0, r0});

    go(0, 2'd0, 64'h0100, 32'd1, lat);
    check(div_ovf && !div_zero && lat == 1, "R5 early overflow", {div_ovf, 8'(lat)}, {1'b1, 8'd1});
    check(quotient == q0, "R8 overflow keeps result", quotient, q0);

    go(1, 2'd0, 64'h0080, 32'd1, lat);
    check(div_ovf && lat == 9, "R6 signed +128 overflow", {div_ovf, 8'(lat)}, {1'b1, 8'd9});
    check(quotient == q0 && remainder == r0, "R8 late overflow keeps result", {quotient, remainder}, {q0, r0});

    go(1, 2'd0, 64'hFF80, 32'd1, lat);
    check(!div_ovf && quotient == 32'h80, "R6 signed -128 fits", {div_ovf, quotient}, {1'b0, 32'h80});
    check(!div_zero, "R11 flag cleared", div_zero, 0);

    @(negedge clk);
    signed_mode = 0; size_sel = 2'd3; dividend = 64'd1_000_000_007; divisor = 32'd1000; start = 1'b1;
    @(negedge clk);
    dividend = 64'd5; divisor = 32'd0;
    repeat (3) @(negedge clk);
    start = 1'b0;
    lat = 4;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check(quotient == 32'd1000000 && remainder == 32'd7 && !div_zero, "R9 start ignored while busy",
          {quotient, remainder}, {32'd1000000, 32'd7});
    check(lat == 33, "R7 latency w32", lat, 33);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] sz; int w; logic [63:0] a, qv, rv, vv;
      sz = 2'($urandom % 4);
      w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
      if (i % 3 == 0) begin
        vv = {32'd0, $urandom} & ((64'd1 << w) - 1);
        if (vv == 0) vv = 1;
        qv = {32'd0, $urandom} & ((64'd1 << w) - 1);
        rv = {32'd0, $urandom} % vv;
        a  = qv * vv + rv;
        go(0, sz, a, 32'(vv), lat);
      end else if (i % 3 == 1) begin
        a = $signed({$urandom, $urandom}) >>> (w + ($urandom % w));
        go(1, sz, a, $urandom >> ($urandom % 32), lat);
      end else begin
        go(i[3], sz, {$urandom, $urandom}, ($urandom % 5 == 0) ? 32'd0 : $urandom, lat);
      end
      repeat ($urandom % 3) @(negedge clk);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule